// File: doc/BRIEF.md
# Touch Detection Signal Processor

This block turns a stream of raw capacitive-sense counts into touch events. Each acquisition burst delivers one count with a one-cycle valid strobe. The block holds a reference level for the untouched key. It tests each new count against that reference with a fixed threshold and a release hysteresis. A possible touch is promoted to a confirmed touch only after a run of consecutive detecting samples. A single cycle pulse marks the confirmation, and another marks the release.

While no touch is pending, the reference follows slow changes in the raw signal one count at a time. It follows falling signals faster than rising ones. As soon as a detection is pending or active, the reference stops moving. A touch that stays active for too long is treated as an obstruction, and the block recalibrates without a release pulse. Recalibration also happens after reset and when the system raises its recalibrate request. A recalibration loads the reference from the next valid sample.

The controller has four states. CAL waits for a sample to load. IDLE tracks drift and watches for detections. FILTER counts consecutive detecting samples. HELD is a confirmed touch. The transitions are:
- load: CAL to IDLE.
- suspect: IDLE to FILTER on a detecting sample.
- doubt: FILTER to IDLE on a non-detecting sample.
- confirm: FILTER to HELD on the last required detecting sample.
- release: HELD to IDLE when the signal falls under the hysteresis level.
- expire: HELD to CAL when the on-duration limit is reached.
- recal: any state to CAL on an external request.

Top module: `touch_sigproc`

## Requirements
- R1: After reset, all flags and pulses are low and `ref_level` is 0. The first valid sample after reset is loaded into `ref_level` and produces no detection.
- R2: A sample is detecting when raw − reference ≥ THRESH (default 10). A difference of THRESH−1 is not detecting. `maybe_touch` is high from the first detecting sample for as long as a touch is pending or confirmed.
- R3: `touch_on_pulse` is high for exactly one cycle, in the cycle after the CONFIRM_N-th consecutive detecting sample (default 4). It is not high after fewer such samples.
- R4: A non-detecting sample before confirmation clears the count at once and drops `maybe_touch`. A fresh run of CONFIRM_N detecting samples is then needed.
- R5: In a confirmed touch, release needs raw − reference < THRESH − HYST (default 8). A difference of 8 or 9 keeps the touch. Release raises `touch_off_pulse` for one cycle and drops `maybe_touch`.
- R6: `ref_level` does not change while `maybe_touch` is high.
- R7: In IDLE, every DN_RATE-th consecutive sample below the reference (default 8) lowers `ref_level` by exactly 1.
- R8: In IDLE, every UP_RATE-th consecutive non-detecting sample above the reference (default 64) raises `ref_level` by exactly 1.
- R9: After MAX_ON_MS `tick_1ms` pulses in a confirmed touch, the block recalibrates. `maybe_touch` falls with no `touch_off_pulse`, and the next valid sample becomes the reference.
- R10: `recal_req` forces recalibration from any state with no pulse. The next valid sample after the request becomes the reference.
- R11: Cycles without `raw_valid` change neither `ref_level` nor `maybe_touch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_count | input | RAW_W | Raw signal count of one burst |
| raw_valid | input | 1 | Strobe qualifying `raw_count` |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| recal_req | input | 1 | External recalibrate request |
| maybe_touch | output | 1 | Touch pending or confirmed |
| touch_on_pulse | output | 1 | One-cycle confirmed touch event |
| touch_off_pulse | output | 1 | One-cycle release event |
| ref_level | output | RAW_W | Current reference level |

## Verification
A wrong integrator count shows as a confirmation pulse one sample early or late, or as a missing pulse. This is visible in the cycle after the fourth detecting sample. A stuck drift counter shows up only over many samples: `ref_level` steps at the wrong sample, up to 64 samples late. The bench therefore counts samples exactly across a whole drift period.

A state lost in HELD shows either as an early `maybe_touch` drop or as a stray release pulse at expiry, and the bench watches both on every tick. A faulty reload is visible only at the first sample after recalibration, so the bench checks `ref_level` at exactly that sample.

// File: rtl/touch_pkg.sv
package touch_pkg;
    typedef enum logic [1:0] {
        ST_CAL    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_FILTER = 2'd2,
        ST_HELD   = 2'd3
    } tstate_e;
endpackage

// File: rtl/touch_cmp.sv
module touch_cmp #(
    parameter int RAW_W  = 14,
    parameter int THRESH = 10,
    parameter int HYST   = 2
) (
    input  logic [RAW_W-1:0] raw,
    input  logic [RAW_W-1:0] ref_lvl,
    output logic             detect,
    output logic             keep,
    output logic             below,
    output logic             above
);
    localparam int DW = RAW_W + 1;
    localparam logic signed [DW-1:0] TH_ON  = DW'(THRESH);
    localparam logic signed [DW-1:0] TH_OFF = DW'(THRESH - HYST);

    logic signed [DW-1:0] diff;

    always_comb begin
        diff   = $signed({1'b0, raw}) - $signed({1'b0, ref_lvl});
        detect = diff >= TH_ON;
        keep   = diff >= TH_OFF;
        below  = raw < ref_lvl;
        above  = raw > ref_lvl;
    end
endmodule

// File: rtl/touch_drift.sv
module touch_drift #(
    parameter int RAW_W   = 14,
    parameter int DN_RATE = 8,
    parameter int UP_RATE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RAW_W-1:0] load_val,
    input  logic             step_en,
    input  logic             below,
    input  logic             above,
    output logic [RAW_W-1:0] ref_q
);
    localparam int DCW = (DN_RATE > 1) ? $clog2(DN_RATE) : 1;
    localparam int UCW = (UP_RATE > 1) ? $clog2(UP_RATE) : 1;
    localparam logic [RAW_W-1:0] REF_MAX = '1;

    logic [DCW-1:0] dn_cnt;
    logic [UCW-1:0] up_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            dn_cnt <= '0;
            up_cnt <= '0;
        end else if (load) begin
            ref_q  <= load_val;
            dn_cnt <= '0;
            up_cnt <= '0;
        end else if (step_en) begin
            if (below) begin
                up_cnt <= '0;
                if (dn_cnt == DCW'(DN_RATE - 1)) begin
                    dn_cnt <= '0;
                    if (ref_q != '0) ref_q <= ref_q - 1'b1;
                end else begin
                    dn_cnt <= dn_cnt + 1'b1;
                end
            end else if (above) begin
                dn_cnt <= '0;
                if (up_cnt == UCW'(UP_RATE - 1)) begin
                    up_cnt <= '0;
                    if (ref_q != REF_MAX) ref_q <= ref_q + 1'b1;
                end else begin
                    up_cnt <= up_cnt + 1'b1;
                end
            end else begin
                dn_cnt <= '0;
                up_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/touch_ontimer.sv
module touch_ontimer #(
    parameter int MAX_ON_MS = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int TW = $clog2(MAX_ON_MS + 1);

    logic [TW-1:0] cnt;

    assign expire = run && tick && (cnt == TW'(MAX_ON_MS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick && !expire) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/touch_sigproc.sv
module touch_sigproc
    import touch_pkg::*;
#(
    parameter int RAW_W     = 14,
    parameter int THRESH    = 10,
    parameter int HYST      = 2,
    parameter int CONFIRM_N = 4,
    parameter int DN_RATE   = 8,
    parameter int UP_RATE   = 64,
    parameter int MAX_ON_MS = 30000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW_W-1:0] raw_count,
    input  logic             raw_valid,
    input  logic             tick_1ms,
    input  logic             recal_req,
    output logic             maybe_touch,
    output logic             touch_on_pulse,
    output logic             touch_off_pulse,
    output logic [RAW_W-1:0] ref_level
);
    localparam int CW = $clog2(CONFIRM_N + 1);

    tstate_e       state, nxt;
    logic [CW-1:0] integ;
    logic          detect, keep, below, above, expire;
    logic          smp;

    assign smp = raw_valid && !recal_req;

    touch_cmp #(.RAW_W(RAW_W), .THRESH(THRESH), .HYST(HYST)) u_cmp (
        .raw(raw_count), .ref_lvl(ref_level),
        .detect(detect), .keep(keep), .below(below), .above(above)
    );

    touch_drift #(.RAW_W(RAW_W), .DN_RATE(DN_RATE), .UP_RATE(UP_RATE)) u_drift (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_CAL && smp), .load_val(raw_count),
        .step_en(state == ST_IDLE && smp && !detect),
        .below(below), .above(above), .ref_q(ref_level)
    );

    touch_ontimer #(.MAX_ON_MS(MAX_ON_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_HELD),
        .tick(tick_1ms), .expire(expire)
    );

    always_comb begin
        nxt = state;
        if (recal_req) begin
            nxt = ST_CAL;
        end else begin
            unique case (state)
                ST_CAL:    if (raw_valid) nxt = ST_IDLE;
                ST_IDLE:   if (raw_valid && detect) nxt = ST_FILTER;
                ST_FILTER: if (raw_valid) begin
                    if (!detect) nxt = ST_IDLE;
                    else if (integ == CW'(CONFIRM_N - 1)) nxt = ST_HELD;
                end
                ST_HELD:   if (expire) nxt = ST_CAL;
                           else if (raw_valid && !keep) nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CAL;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) integ <= '0;
        else if (nxt == ST_FILTER) begin
            if (state == ST_IDLE)  integ <= CW'(1);
            else if (smp)          integ <= integ + 1'b1;
        end else begin
            integ <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maybe_touch     <= 1'b0;
            touch_on_pulse  <= 1'b0;
            touch_off_pulse <= 1'b0;
        end else begin
            maybe_touch     <= (nxt == ST_FILTER) || (nxt == ST_HELD);
            touch_on_pulse  <= (state == ST_FILTER) && (nxt == ST_HELD);
            touch_off_pulse <= (state == ST_HELD) && (nxt == ST_IDLE);
        end
    end
endmodule

// File: rtl/touch_sigproc_chk.sv
module touch_sigproc_chk #(
    parameter int RAW_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             raw_valid,
    input logic             maybe_touch,
    input logic             touch_on_pulse,
    input logic             touch_off_pulse,
    input logic [RAW_W-1:0] ref_level
);
    AST_ON_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        touch_on_pulse |=> !touch_on_pulse); // R3
    AST_ON_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        touch_on_pulse |-> maybe_touch); // R3
    AST_OFF_AFTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        touch_off_pulse |-> (!maybe_touch && $past(maybe_touch))); // R5
    AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(maybe_touch) && maybe_touch) |-> $stable(ref_level)); // R6
    AST_NO_SAMPLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(raw_valid) |-> $stable(ref_level)); // R11
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(touch_on_pulse && touch_off_pulse)); // R5
endmodule

bind touch_sigproc touch_sigproc_chk #(.RAW_W(RAW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid),
    .maybe_touch(maybe_touch), .touch_on_pulse(touch_on_pulse),
    .touch_off_pulse(touch_off_pulse), .ref_level(ref_level)
);

// File: tb/sim_touch_sigproc.sv
`timescale 1ns/1ps
module sim_touch_sigproc;
    localparam int RW = 14;
    localparam int MAXON = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] raw_count = '0;
    logic          raw_valid = 1'b0;
    logic          tick_1ms = 1'b0;
    logic          recal_req = 1'b0;
    logic          maybe_touch, touch_on_pulse, touch_off_pulse;
    logic [RW-1:0] ref_level;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    bit  on_seen, off_seen;

    always #2 clk = ~clk;

    touch_sigproc #(.RAW_W(RW), .MAX_ON_MS(MAXON)) u0 (
        .clk(clk), .rst_n(rst_n), .raw_count(raw_count), .raw_valid(raw_valid),
        .tick_1ms(tick_1ms), .recal_req(recal_req), .maybe_touch(maybe_touch),
        .touch_on_pulse(touch_on_pulse), .touch_off_pulse(touch_off_pulse),
        .ref_level(ref_level)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic samp(input int v);
        raw_count = RW'(v);
        raw_valid = 1'b1;
        @(negedge clk);
        raw_valid = 1'b0;
        on_seen  = touch_on_pulse;
        off_seen = touch_off_pulse;
    endtask

    task automatic recal();
        recal_req = 1'b1;
        @(negedge clk);
        recal_req = 1'b0;
        chk("R10", "flag after request", maybe_touch, 0);
        chk("R10", "no off pulse", touch_off_pulse, 0);
    endtask

    task automatic t_reset();
        chk("R1", "flag", maybe_touch, 0);
        chk("R1", "on", touch_on_pulse, 0);
        chk("R1", "off", touch_off_pulse, 0);
        chk("R1", "ref", ref_level, 0);
        samp(1000);
        chk("R1", "loaded ref", ref_level, 1000);
        chk("R1", "no detect on load", maybe_touch, 0);
    endtask

    task automatic t_confirm_hyst();
        for (int i = 0; i < 3; i++) begin
            samp(1010);
            chk("R2", "pending flag", maybe_touch, 1);
            chk("R3", "early pulse", on_seen, 0);
        end
        samp(1010);
        chk("R3", "confirm pulse", on_seen, 1);
        @(negedge clk);
        chk("R3", "pulse one cycle", touch_on_pulse, 0);
        samp(1009);
        chk("R5", "hold at 9", maybe_touch, 1);
        samp(1008);
        chk("R5", "hold at 8", maybe_touch, 1);
        chk("R5", "no off at 8", off_seen, 0);
        samp(1007);
        chk("R5", "release pulse", off_seen, 1);
        chk("R5", "flag dropped", maybe_touch, 0);
        chk("R6", "ref frozen", ref_level, 1000);
    endtask

    task automatic t_glitch();
        for (int i = 0; i < 3; i++) samp(1012);
        samp(1000);
        chk("R4", "flag reset", maybe_touch, 0);
        for (int i = 0; i < 3; i++) begin
            samp(1012);
            chk("R4", "no pulse on restart", on_seen, 0);
        end
        samp(1012);
        chk("R4", "confirm after fresh run", on_seen, 1);
        samp(1000);
        chk("R5", "release", off_seen, 1);
    endtask

    task automatic t_boundary();
        samp(1009);
        chk("R2", "9 is not detecting", maybe_touch, 0);
    endtask

    task automatic t_ignore();
        raw_count = RW'(3000);
        repeat (5) @(negedge clk);
        chk("R11", "ref unchanged", ref_level, 1000);
        chk("R11", "flag unchanged", maybe_touch, 0);
    endtask

    task automatic t_drift_down();
        recal();
        samp(1000);
        chk("R10", "reload", ref_level, 1000);
        for (int i = 0; i < 7; i++) samp(990);
        chk("R7", "no step before 8", ref_level, 1000);
        samp(990);
        chk("R7", "step at 8", ref_level, 999);
        for (int i = 0; i < 8; i++) samp(990);
        chk("R7", "second step", ref_level, 998);
    endtask

    task automatic t_drift_up();
        recal();
        samp(1000);
        for (int i = 0; i < 63; i++) samp(1005);
        chk("R8", "no step before 64", ref_level, 1000);
        samp(1005);
        chk("R8", "step at 64", ref_level, 1001);
    endtask

    task automatic t_maxon();
        bit stray;
        recal();
        samp(1000);
        for (int i = 0; i < 4; i++) samp(1020);
        chk("R9", "confirmed", on_seen, 1);
        stray = 0;
        for (int i = 0; i < MAXON - 1; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            if (touch_off_pulse || !maybe_touch) stray = 1;
            @(negedge clk);
        end
        chk("R9", "held before limit", stray, 0);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        chk("R9", "no off pulse", touch_off_pulse, 0);
        chk("R9", "flag dropped", maybe_touch, 0);
        samp(1050);
        chk("R9", "reloaded", ref_level, 1050);
    endtask

    task automatic t_ext_recal();
        for (int i = 0; i < 4; i++) samp(1060);
        chk("R10", "confirmed", on_seen, 1);
        recal();
        samp(1200);
        chk("R10", "reload after request", ref_level, 1200);
        chk("R10", "no detect", maybe_touch, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_confirm_hyst();
        t_glitch();
        t_boundary();
        t_ignore();
        t_drift_down();
        t_drift_up();
        t_maxon();
        t_ext_recal();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule